// File: doc/BRIEF.md
# Freezable Dual 64-bit Time Base

This block keeps two free-running 64-bit counts: a main time base and an alternate time base. Both step by one on every cycle in which the tick strobe is high, provided the run input is high. When run goes low, both counts hold their present values, and they pick up again from those values once run returns high. Stopping or starting the block again while it is already in that state changes nothing. Tick generation is handled outside this block.

Software reaches the two counts through a 32-bit register port. A two-bit select picks the base and the half. A write to one half loads that half from the write data and leaves the other half as it was. The read data is a combinational view of the selected half.

Top module: `tbp_dual_timebase`

## Requirements
- R1: After reset both counts are zero, and they count as soon as run and tick are high.
- R2: sel[1] picks the base (0 = main, 1 = alternate) and sel[0] picks the half (0 = bits 31:0, 1 = bits 63:32). rdata shows that half of the selected count in the same cycle.
- R3: A write with sel[0] = 0 loads bits 31:0 of the selected base from wdata on the clock edge and keeps bits 63:32.
- R4: A write with sel[0] = 1 loads bits 63:32 of the selected base from wdata on the clock edge and keeps bits 31:0.
- R5: A write to one base leaves the value of the other base unchanged. The other base still counts a tick taken in the same cycle.
- R6: While run is low, ticks are ignored and both counts hold. Holding run low for longer has no further effect.
- R7: While run is high, each tick adds exactly one to both counts. After a freeze, counting resumes from the frozen value with no jump.
- R8: When bits 31:0 are all ones, a tick clears them and increments bits 63:32 on the same edge, so a 64-bit value is never seen torn.
- R9: If a write and a tick occur in the same cycle, the written base takes the written half, keeps its other half, and drops that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one increment per high cycle |
| run | input | 1 | High to count, low to freeze both bases |
| sel | input | 2 | Base (bit 1) and half (bit 0) select |
| wr_en | input | 1 | Write strobe for the selected half |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Selected half of the selected count |

## Verification
The assertions assume that the inputs are stable at the sampling edge and that each cycle carries at most one write, whose target is fully described by sel. They also assume that run and tick are never unknown once reset is released. The bench drives every input at the falling edge and keeps all of them at defined levels at all times. For reads, it drops tick for that cycle so that the value it samples stays fixed while the check is made.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_e;

   typedef enum logic {
      BASE_MAIN = 1'b0,
      BASE_ALT  = 1'b1
   } base_sel_e;

   localparam int unsigned NUM_BASES = 2;
endpackage

// File: rtl/tbp_counter.sv
module tbp_counter #(
   parameter int unsigned HALF_W      = 32,
   parameter bit          SPLIT_CARRY = 1'b1,
   localparam int unsigned CNT_W      = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   output logic [CNT_W-1:0]  count
);
   logic [HALF_W-1:0] lo_q, hi_q;
   logic [HALF_W-1:0] lo_inc, hi_inc;

   generate
      if (SPLIT_CARRY) begin : g_split
         // two half-width adders; carry is the all-ones detect of the low half
         logic carry;
         assign carry  = &lo_q;
         assign lo_inc = lo_q + {{(HALF_W-1){1'b0}}, 1'b1};
         assign hi_inc = hi_q + {{(HALF_W-1){1'b0}}, carry};
      end else begin : g_full
         logic [CNT_W-1:0] sum;
         assign sum    = {hi_q, lo_q} + {{(CNT_W-1){1'b0}}, 1'b1};
         assign lo_inc = sum[HALF_W-1:0];
         assign hi_inc = sum[CNT_W-1:HALF_W];
      end
   endgenerate

   // a write wins over a tick; only the written half changes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (wr_lo) begin
         lo_q <= wdata;
      end else if (wr_hi) begin
         hi_q <= wdata;
      end else if (adv) begin
         lo_q <= lo_inc;
         hi_q <= hi_inc;
      end
   end

   assign count = {hi_q, lo_q};
endmodule

// File: rtl/tbp_write_decode.sv
module tbp_write_decode #(
   parameter int unsigned NB = 2,
   localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          wr_en,
   input  logic [BW:0]   sel,
   output logic [NB-1:0] wr_lo,
   output logic [NB-1:0] wr_hi
);
   import tbp_pkg::*;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_dec
         logic hit;
         assign hit      = wr_en && (sel[BW:1] == BW'(b));
         assign wr_lo[b] = hit && (sel[0] == HALF_LO);
         assign wr_hi[b] = hit && (sel[0] == HALF_HI);
      end
   endgenerate
endmodule

// File: rtl/tbp_read_mux.sv
module tbp_read_mux #(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned NB     = 2,
   localparam int unsigned BW    = (NB > 1) ? $clog2(NB) : 1,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input  logic [NB-1:0][CNT_W-1:0] counts,
   input  logic [BW:0]              sel,
   output logic [HALF_W-1:0]        rdata
);
   import tbp_pkg::*;

   logic [CNT_W-1:0] picked;

   always_comb begin
      picked = '0;
      for (int b = 0; b < NB; b++) begin
         if (sel[BW:1] == BW'(b)) picked = counts[b];
      end
   end

   assign rdata = (sel[0] == HALF_HI) ? picked[CNT_W-1:HALF_W] : picked[HALF_W-1:0];
endmodule

// File: rtl/tbp_dual_timebase.sv
module tbp_dual_timebase #(
   parameter int unsigned HALF_W      = 32,
   parameter bit          SPLIT_CARRY = 1'b1,
   localparam int unsigned CNT_W      = 2 * HALF_W,
   localparam int unsigned NB         = tbp_pkg::NUM_BASES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic [1:0]        sel,
   input  logic              wr_en,
   input  logic [HALF_W-1:0] wdata,
   output logic [HALF_W-1:0] rdata
);
   generate
      if (HALF_W < 8) begin : g_bad_width
         $error("tbp_dual_timebase: HALF_W must be at least 8");
      end
      if (NB != 2) begin : g_bad_count
         $error("tbp_dual_timebase: select encoding needs exactly two bases");
      end
   endgenerate

   logic                     advance;
   logic [NB-1:0]            wr_lo, wr_hi;
   logic [NB-1:0][CNT_W-1:0] counts;
   logic [CNT_W-1:0]         main_cnt, alt_cnt;

   // one shared freeze control: a gated tick reaches both bases together
   assign advance = tick && run;

   tbp_write_decode #(.NB(NB)) u_dec (
      .wr_en (wr_en),
      .sel   (sel),
      .wr_lo (wr_lo),
      .wr_hi (wr_hi)
   );

   generate
      for (genvar b = 0; b < NB; b++) begin : g_base
         tbp_counter #(.HALF_W(HALF_W), .SPLIT_CARRY(SPLIT_CARRY)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (advance),
            .wr_lo (wr_lo[b]),
            .wr_hi (wr_hi[b]),
            .wdata (wdata),
            .count (counts[b])
         );
      end
   endgenerate

   assign main_cnt = counts[0];
   assign alt_cnt  = counts[1];

   tbp_read_mux #(.HALF_W(HALF_W), .NB(NB)) u_rd (
      .counts (counts),
      .sel    (sel),
      .rdata  (rdata)
   );
endmodule

// File: rtl/tbp_dual_timebase_chk.sv
module tbp_dual_timebase_chk #(
   parameter int unsigned HALF_W = 32,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              run,
   input logic [1:0]        sel,
   input logic              wr_en,
   input logic [HALF_W-1:0] wdata,
   input logic [HALF_W-1:0] rdata,
   input logic [CNT_W-1:0]  main_cnt,
   input logic [CNT_W-1:0]  alt_cnt
);
   assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> ($stable(main_cnt) && $stable(alt_cnt)));

   assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !wr_en) |=>
         (main_cnt == $past(main_cnt) + 1'b1) && (alt_cnt == $past(alt_cnt) + 1'b1));

   assert_lo_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'b00) |=>
         (main_cnt[HALF_W-1:0] == $past(wdata)) &&
         (main_cnt[CNT_W-1:HALF_W] == $past(main_cnt[CNT_W-1:HALF_W])));

   assert_hi_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'b11) |=>
         (alt_cnt[CNT_W-1:HALF_W] == $past(wdata)) &&
         (alt_cnt[HALF_W-1:0] == $past(alt_cnt[HALF_W-1:0])));

   assert_other_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel[1] && !(run && tick)) |=> $stable(alt_cnt));

   assert_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'b01) |-> (rdata == main_cnt[CNT_W-1:HALF_W]));
endmodule

bind tbp_dual_timebase tbp_dual_timebase_chk #(.HALF_W(HALF_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .run      (run),
   .sel      (sel),
   .wr_en    (wr_en),
   .wdata    (wdata),
   .rdata    (rdata),
   .main_cnt (main_cnt),
   .alt_cnt  (alt_cnt)
);

// File: tb/tb_tbp_dual_timebase.sv
`timescale 1ns/1ps
module tb_tbp_dual_timebase;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        run = 1'b1;
   logic [1:0]  sel = 2'b00;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int unsigned n_checks = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;

   logic [63:0] model [2];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   event        sample_ev;

   always #4 clk = ~clk;

   tbp_dual_timebase dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
      .sel(sel), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
   );

   // one clock of stimulus; the model follows the requirement text
   task automatic cycle(input logic t, input logic r, input logic w,
                        input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      tick = t; run = r; wr_en = w; sel = s; wdata = d;
      @(posedge clk);
      for (int b = 0; b < 2; b++) begin
         if (w && s[1] == b[0]) begin
            if (s[0]) model[b][63:32] = d;
            else      model[b][31:0]  = d;
         end else if (t && r) begin
            model[b] = model[b] + 64'd1;
         end
      end
   endtask

   // driver: select a half with tick low and queue the expected value
   task automatic read_chk(input logic [1:0] s, input string tag);
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0; sel = s;
      exp_q.push_back(s[0] ? model[s[1]][63:32] : model[s[1]][31:0]);
      tag_q.push_back(tag);
      #1 ->sample_ev;
      @(posedge clk);
   endtask

   // monitor: pop and compare
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rdata !== e) begin
               n_fail++;
               $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      model[0] = '0; model[1] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1, R2: reset values on all four halves
      read_chk(2'b00, "R1 main lo"); read_chk(2'b01, "R1 main hi");
      read_chk(2'b10, "R1 alt lo");  read_chk(2'b11, "R2 alt hi");

      // R7: both bases step together
      for (int i = 0; i < 5; i++) cycle(1, 1, 0, 2'b00, 32'h0);
      read_chk(2'b00, "R7 main after 5"); read_chk(2'b10, "R7 alt after 5");

      // R3: lower-half write keeps the upper half
      cycle(0, 1, 1, 2'b00, 32'hFFFF_FFFE);
      read_chk(2'b00, "R3 main lo"); read_chk(2'b01, "R3 main hi kept");

      // R4, R5: upper write on alt leaves its lower half and main untouched
      cycle(0, 1, 1, 2'b11, 32'h0000_1234);
      read_chk(2'b11, "R4 alt hi"); read_chk(2'b10, "R4 alt lo kept");
      read_chk(2'b00, "R5 main untouched");

      // R8: carry crosses into the upper half
      for (int i = 0; i < 3; i++) cycle(1, 1, 0, 2'b00, 32'h0);
      read_chk(2'b00, "R8 main lo wrap"); read_chk(2'b01, "R8 main hi carry");

      // R6: frozen, ticks ignored, repeated stop harmless
      for (int i = 0; i < 10; i++) cycle(1, 0, 0, 2'b00, 32'h0);
      read_chk(2'b00, "R6 main frozen"); read_chk(2'b10, "R6 alt frozen");
      read_chk(2'b11, "R6 alt hi frozen");

      // R7: resume from frozen value
      for (int i = 0; i < 2; i++) cycle(1, 1, 0, 2'b00, 32'h0);
      read_chk(2'b00, "R7 main resumed"); read_chk(2'b10, "R7 alt resumed");

      // R9, R5: write collides with tick on main; alt still counts
      cycle(1, 1, 1, 2'b00, 32'hA5A5_0000);
      read_chk(2'b00, "R9 main written"); read_chk(2'b01, "R9 main hi kept");
      read_chk(2'b10, "R5 alt counted tick");

      // R9 on the upper half of alt
      cycle(1, 1, 1, 2'b11, 32'hDEAD_BEEF);
      read_chk(2'b11, "R9 alt hi written"); read_chk(2'b10, "R9 alt lo kept");
      read_chk(2'b00, "R5 main counted tick");

      // R8: full 64-bit rollover on alt
      cycle(0, 1, 1, 2'b10, 32'hFFFF_FFFF);
      cycle(0, 1, 1, 2'b11, 32'hFFFF_FFFF);
      cycle(1, 1, 0, 2'b00, 32'h0);
      read_chk(2'b10, "R8 alt lo wrap"); read_chk(2'b11, "R8 alt hi wrap");

      // R1: reset again clears both
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk); model[0] = '0; model[1] = '0;
      @(negedge clk) rst_n = 1'b1;
      read_chk(2'b01, "R1 main hi after reset"); read_chk(2'b10, "R1 alt lo after reset");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule